// File: doc/BRIEF.md
# Iterative DES Block Cipher Core

This block encrypts or decrypts one 64-bit block under a 64-bit key using the Data Encryption Standard. It has a single round datapath that it uses sixteen times, one round per rising clock edge. The input block goes through the fixed initial permutation and is split into a left and a right 32-bit register. Each round expands the right half to 48 bits and mixes in that round's subkey. Eight 6-to-4 substitution tables, read in parallel, and the P permutation then produce the new right half. The subkeys are made one per round from two rotating 28-bit key registers, so no table of sixteen subkeys is stored.

The core has no separate reset. An active-low enable acts as one. While the enable is high the core is idle and its outputs are cleared. While it is low, the core takes the block, key and direction on the next rising edge and runs sixteen rounds. It then presents the result together with a one-cycle done pulse. If the enable stays low, the next block is taken on the edge that ends the done cycle, so one block completes every seventeen cycles.

Top module: `des_iter_core`

## Requirements
- R1: With `dec_sel` = 0, `blk_out` equals the DES encryption of `blk_in` under `key_in`. Bit 63 of each bus is the first bit in standard DES numbering.
- R2: With `dec_sel` = 1, `blk_out` equals the DES decryption of `blk_in` under `key_in`, so decrypting a ciphertext returns its plaintext.
- R3: The eight key bits at positions 0, 8, 16, 24, 32, 40, 48 and 56 (the lowest bit of each byte) have no effect on the result.
- R4: The block is loaded on the first rising edge at which `en_n` is low and the core is idle. `done` is high for exactly the one cycle that follows the seventeenth rising edge counted from and including that load edge, and it is low in every other cycle.
- R5: Changes to `blk_in`, `key_in` or `dec_sel` after the load edge do not alter the result of the block in progress.
- R6: Raising `en_n` during a block abandons it. No `done` pulse follows for that block, even when the abort comes just before the final round edge, and the next block after re-enabling gives a correct result.
- R7: At each rising edge where `en_n` is high, `done` and `blk_out` are cleared to zero.
- R8: While `en_n` stays low, a new block is loaded on the edge that ends the `done` cycle, and its result is correct.
- R9: Between `done` pulses, `blk_out` holds the last result, or zero after a disable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| en_n | input | 1 | Active-low enable; high forces idle and clears outputs |
| blk_in | input | 64 | Plaintext or ciphertext block, sampled on the load edge |
| key_in | input | 64 | Key with parity bits, sampled on the load edge |
| dec_sel | input | 1 | 0 encrypts, 1 decrypts; sampled on the load edge |
| blk_out | output | 64 | Result block, held until the next result or disable |
| done | output | 1 | One-cycle pulse marking a new result on `blk_out` |

## Verification
When the enable stays low, two events share one clock cycle: a result is presented with its `done` pulse, and the next block is taken on the edge that closes that cycle. The bench provokes this by placing the next block's data, key and direction on the inputs during the `done` cycle. A scoreboard then checks both results, and the bench also checks that `done` rises exactly seventeen edges after each load. A second clash is an abort that lands just before the final round edge. The bench judges it by the absence of any `done` pulse and by the next block's correct result.

// File: rtl/des_pkg.sv
package des_pkg;

   localparam int BLK_W    = 64;
   localparam int HALF_W   = 32;
   localparam int KHALF_W  = 28;
   localparam int SUBKEY_W = 48;
   localparam int NUM_SBOX = 8;

   localparam int IP_T [64] = '{
      58,50,42,34,26,18,10,2, 60,52,44,36,28,20,12,4,
      62,54,46,38,30,22,14,6, 64,56,48,40,32,24,16,8,
      57,49,41,33,25,17,9,1,  59,51,43,35,27,19,11,3,
      61,53,45,37,29,21,13,5, 63,55,47,39,31,23,15,7};

   localparam int FP_T [64] = '{
      40,8,48,16,56,24,64,32, 39,7,47,15,55,23,63,31,
      38,6,46,14,54,22,62,30, 37,5,45,13,53,21,61,29,
      36,4,44,12,52,20,60,28, 35,3,43,11,51,19,59,27,
      34,2,42,10,50,18,58,26, 33,1,41,9,49,17,57,25};

   localparam int E_T [48] = '{
      32,1,2,3,4,5,     4,5,6,7,8,9,       8,9,10,11,12,13,
      12,13,14,15,16,17, 16,17,18,19,20,21, 20,21,22,23,24,25,
      24,25,26,27,28,29, 28,29,30,31,32,1};

   localparam int P_T [32] = '{
      16,7,20,21,29,12,28,17, 1,15,23,26,5,18,31,10,
      2,8,24,14,32,27,3,9,    19,13,30,6,22,11,4,25};

   localparam int PC1_T [56] = '{
      57,49,41,33,25,17,9,  1,58,50,42,34,26,18,
      10,2,59,51,43,35,27,  19,11,3,60,52,44,36,
      63,55,47,39,31,23,15, 7,62,54,46,38,30,22,
      14,6,61,53,45,37,29,  21,13,5,28,20,12,4};

   localparam int PC2_T [48] = '{
      14,17,11,24,1,5,   3,28,15,6,21,10,  23,19,12,4,26,8,
      16,7,27,20,13,2,   41,52,31,37,47,55, 30,40,51,45,33,48,
      44,49,39,56,34,53, 46,42,50,36,29,32};

   localparam int SB1 [64] = '{
      14,4,13,1,2,15,11,8,3,10,6,12,5,9,0,7,
      0,15,7,4,14,2,13,1,10,6,12,11,9,5,3,8,
      4,1,14,8,13,6,2,11,15,12,9,7,3,10,5,0,
      15,12,8,2,4,9,1,7,5,11,3,14,10,0,6,13};
   localparam int SB2 [64] = '{
      15,1,8,14,6,11,3,4,9,7,2,13,12,0,5,10,
      3,13,4,7,15,2,8,14,12,0,1,10,6,9,11,5,
      0,14,7,11,10,4,13,1,5,8,12,6,9,3,2,15,
      13,8,10,1,3,15,4,2,11,6,7,12,0,5,14,9};
   localparam int SB3 [64] = '{
      10,0,9,14,6,3,15,5,1,13,12,7,11,4,2,8,
      13,7,0,9,3,4,6,10,2,8,5,14,12,11,15,1,
      13,6,4,9,8,15,3,0,11,1,2,12,5,10,14,7,
      1,10,13,0,6,9,8,7,4,15,14,3,11,5,2,12};
   localparam int SB4 [64] = '{
      7,13,14,3,0,6,9,10,1,2,8,5,11,12,4,15,
      13,8,11,5,6,15,0,3,4,7,2,12,1,10,14,9,
      10,6,9,0,12,11,7,13,15,1,3,14,5,2,8,4,
      3,15,0,6,10,1,13,8,9,4,5,11,12,7,2,14};
   localparam int SB5 [64] = '{
      2,12,4,1,7,10,11,6,8,5,3,15,13,0,14,9,
      14,11,2,12,4,7,13,1,5,0,15,10,3,9,8,6,
      4,2,1,11,10,13,7,8,15,9,12,5,6,3,0,14,
      11,8,12,7,1,14,2,13,6,15,0,9,10,4,5,3};
   localparam int SB6 [64] = '{
      12,1,10,15,9,2,6,8,0,13,3,4,14,7,5,11,
      10,15,4,2,7,12,9,5,6,1,13,14,0,11,3,8,
      9,14,15,5,2,8,12,3,7,0,4,10,1,13,11,6,
      4,3,2,12,9,5,15,10,11,14,1,7,6,0,8,13};
   localparam int SB7 [64] = '{
      4,11,2,14,15,0,8,13,3,12,9,7,5,10,6,1,
      13,0,11,7,4,9,1,10,14,3,5,12,2,15,8,6,
      1,4,11,13,12,3,7,14,10,15,6,8,0,5,9,2,
      6,11,13,8,1,4,10,7,9,5,0,15,14,2,3,12};
   localparam int SB8 [64] = '{
      13,2,8,4,6,15,11,1,10,9,3,14,5,0,12,7,
      1,15,13,8,10,3,7,4,12,5,6,11,0,14,9,2,
      7,11,4,1,9,12,14,2,0,6,10,13,15,3,5,8,
      2,1,14,7,4,10,8,13,15,12,9,0,3,5,6,11};

   // Tables count bits from 1 at the most significant end.
   function automatic logic [63:0] perm_ip(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[6'(63 - i)] = x[6'(64 - IP_T[i])];
      return y;
   endfunction

   function automatic logic [63:0] perm_fp(input logic [63:0] x);
      logic [63:0] y;
      for (int i = 0; i < 64; i++) y[6'(63 - i)] = x[6'(64 - FP_T[i])];
      return y;
   endfunction

   function automatic logic [47:0] perm_e(input logic [31:0] x);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[6'(47 - i)] = x[5'(32 - E_T[i])];
      return y;
   endfunction

   function automatic logic [31:0] perm_p(input logic [31:0] x);
      logic [31:0] y;
      for (int i = 0; i < 32; i++) y[5'(31 - i)] = x[5'(32 - P_T[i])];
      return y;
   endfunction

   function automatic logic [55:0] perm_pc1(input logic [63:0] x);
      logic [55:0] y;
      for (int i = 0; i < 56; i++) y[6'(55 - i)] = x[6'(64 - PC1_T[i])];
      return y;
   endfunction

   function automatic logic [47:0] perm_pc2(input logic [55:0] x);
      logic [47:0] y;
      for (int i = 0; i < 48; i++) y[6'(47 - i)] = x[6'(56 - PC2_T[i])];
      return y;
   endfunction

   // Per-round rotation of the key halves; round index counts from 0.
   function automatic logic [1:0] rot_amount(input logic [3:0] rnd, input logic dec);
      logic single;
      single = (rnd == 4'd0) || (rnd == 4'd1) || (rnd == 4'd8) || (rnd == 4'd15);
      if (dec && rnd == 4'd0) return 2'd0;
      return single ? 2'd1 : 2'd2;
   endfunction

endpackage

// File: rtl/des_sbox.sv
module des_sbox #(
   parameter int IDX = 0
) (
   input  logic [5:0] grp,
   output logic [3:0] nib
);
   logic [5:0] sel;
   assign sel = {grp[5], grp[0], grp[4:1]};

   if (IDX < 0 || IDX > 7) begin : g_bad
      $error("des_sbox: IDX out of range");
   end

   case (IDX)
      0: begin : g_s1 assign nib = 4'(des_pkg::SB1[sel]); end
      1: begin : g_s2 assign nib = 4'(des_pkg::SB2[sel]); end
      2: begin : g_s3 assign nib = 4'(des_pkg::SB3[sel]); end
      3: begin : g_s4 assign nib = 4'(des_pkg::SB4[sel]); end
      4: begin : g_s5 assign nib = 4'(des_pkg::SB5[sel]); end
      5: begin : g_s6 assign nib = 4'(des_pkg::SB6[sel]); end
      6: begin : g_s7 assign nib = 4'(des_pkg::SB7[sel]); end
      default: begin : g_s8 assign nib = 4'(des_pkg::SB8[sel]); end
   endcase
endmodule

// File: rtl/des_round.sv
module des_round
   import des_pkg::*;
(
   input  logic [HALF_W-1:0]   left_in,
   input  logic [HALF_W-1:0]   right_in,
   input  logic [SUBKEY_W-1:0] subkey,
   output logic [HALF_W-1:0]   right_out
);
   localparam int GRP_W = SUBKEY_W / NUM_SBOX;
   localparam int NIB_W = HALF_W / NUM_SBOX;

   logic [SUBKEY_W-1:0] mixed;
   logic [HALF_W-1:0]   subst;

   assign mixed = perm_e(right_in) ^ subkey;

   for (genvar j = 0; j < NUM_SBOX; j++) begin : g_box
      des_sbox #(.IDX(j)) u_box (
         .grp (mixed[SUBKEY_W-1-GRP_W*j -: GRP_W]),
         .nib (subst[HALF_W-1-NIB_W*j -: NIB_W])
      );
   end

   assign right_out = left_in ^ perm_p(subst);
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
   import des_pkg::*;
#(
   parameter int CNT_W = 4
) (
   input  logic                clk,
   input  logic                load,
   input  logic                step,
   input  logic [BLK_W-1:0]    key_in,
   input  logic                dec,
   input  logic [CNT_W-1:0]    rnd,
   output logic [SUBKEY_W-1:0] subkey
);
   logic [KHALF_W-1:0] c_q, d_q, c_rot, d_rot;
   logic [55:0]        pc1;
   logic [1:0]         amt;

   assign pc1 = perm_pc1(key_in);
   assign amt = rot_amount(4'(rnd), dec);

   function automatic logic [KHALF_W-1:0] rot(input logic [KHALF_W-1:0] x,
                                              input logic [1:0] n, input logic right);
      case ({right, n})
         3'b001:  return {x[KHALF_W-2:0], x[KHALF_W-1]};
         3'b010:  return {x[KHALF_W-3:0], x[KHALF_W-1:KHALF_W-2]};
         3'b101:  return {x[0], x[KHALF_W-1:1]};
         3'b110:  return {x[1:0], x[KHALF_W-1:2]};
         default: return x;
      endcase
   endfunction

   assign c_rot  = rot(c_q, amt, dec);
   assign d_rot  = rot(d_q, amt, dec);
   assign subkey = perm_pc2({c_rot, d_rot});

   always_ff @(posedge clk) begin
      if (load) begin
         c_q <= pc1[55:28];
         d_q <= pc1[27:0];
      end else if (step) begin
         c_q <= c_rot;
         d_q <= d_rot;
      end
   end
endmodule

// File: rtl/des_iter_core.sv
module des_iter_core
   import des_pkg::*;
#(
   parameter int ROUNDS     = 16,
   parameter int DATA_WIDTH = 64
) (
   input  logic                  clk,
   input  logic                  en_n,
   input  logic [DATA_WIDTH-1:0] blk_in,
   input  logic [DATA_WIDTH-1:0] key_in,
   input  logic                  dec_sel,
   output logic [DATA_WIDTH-1:0] blk_out,
   output logic                  done
);
   localparam int CNT_W = $clog2(ROUNDS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS - 1);

   if (ROUNDS != 16) begin : g_bad_rounds
      $error("des_iter_core: key rotation schedule needs ROUNDS == 16");
   end
   if (DATA_WIDTH != BLK_W) begin : g_bad_width
      $error("des_iter_core: DATA_WIDTH must be 64");
   end

   logic                  busy_q;
   logic [CNT_W-1:0]      rnd_q;
   logic                  dec_q;
   logic [HALF_W-1:0]     left_q, right_q, right_nx;
   logic [SUBKEY_W-1:0]   subkey;
   logic [BLK_W-1:0]      ip_blk;
   logic                  load, step;

   assign ip_blk = perm_ip(blk_in);
   assign load   = !en_n && !busy_q;
   assign step   = !en_n && busy_q;

   des_key_sched #(.CNT_W(CNT_W)) u_ksched (
      .clk    (clk),
      .load   (load),
      .step   (step),
      .key_in (key_in),
      .dec    (dec_q),
      .rnd    (rnd_q),
      .subkey (subkey)
   );

   des_round u_round (
      .left_in   (left_q),
      .right_in  (right_q),
      .subkey    (subkey),
      .right_out (right_nx)
   );

   always_ff @(posedge clk) begin
      if (en_n) begin
         busy_q  <= 1'b0;
         rnd_q   <= '0;
         done    <= 1'b0;
         blk_out <= '0;
      end else begin
         done <= 1'b0;
         if (!busy_q) begin
            busy_q  <= 1'b1;
            rnd_q   <= '0;
            dec_q   <= dec_sel;
            left_q  <= ip_blk[BLK_W-1:HALF_W];
            right_q <= ip_blk[HALF_W-1:0];
         end else begin
            left_q  <= right_q;
            right_q <= right_nx;
            rnd_q   <= rnd_q + 1'b1;
            if (rnd_q == LAST) begin
               busy_q  <= 1'b0;
               done    <= 1'b1;
               blk_out <= perm_fp({right_nx, right_q});
            end
         end
      end
   end
endmodule

// File: rtl/des_iter_core_chk.sv
module des_iter_core_chk #(
   parameter int ROUNDS = 16,
   parameter int CNT_W  = 4
) (
   input logic             clk,
   input logic             en_n,
   input logic             busy,
   input logic [CNT_W-1:0] rnd,
   input logic             done,
   input logic [63:0]      dout
);
   // R4: result pulse lasts one cycle
   a_r4_done_single: assert property (@(posedge clk) disable iff (en_n)
      done |=> !done);

   // R4: a run ends only with a result pulse
   a_r4_run_end_done: assert property (@(posedge clk) disable iff (en_n)
      $fell(busy) |-> done);

   // R4: rounds advance by one each cycle
   a_r4_round_step: assert property (@(posedge clk) disable iff (en_n)
      (busy && rnd != CNT_W'(ROUNDS - 1)) |=> (busy && rnd == $past(rnd) + 1'b1));

   // R7: disable clears outputs
   a_r7_off_clear: assert property (@(posedge clk)
      en_n |=> (!done && dout == 64'd0));

   // R8: next block starts right after the result cycle
   a_r8_reload: assert property (@(posedge clk) disable iff (en_n)
      done |=> (busy && rnd == '0));

   // R9: output only moves with a new result
   a_r9_out_hold: assert property (@(posedge clk) disable iff (en_n)
      !$rose(done) |-> $stable(dout));
endmodule

bind des_iter_core des_iter_core_chk #(.ROUNDS(ROUNDS), .CNT_W(CNT_W)) u_chk (
   .clk  (clk),
   .en_n (en_n),
   .busy (busy_q),
   .rnd  (rnd_q),
   .done (done),
   .dout (blk_out)
);

// File: tb/des_iter_core_tb.sv
module des_iter_core_tb;
   logic        clk = 1'b0;
   logic        en_n = 1'b1;
   logic [63:0] blk_in = '0, key_in = '0;
   logic        dec_sel = 1'b0;
   logic [63:0] blk_out;
   logic        done;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;

   typedef struct { logic [63:0] val; string tag; } exp_t;
   exp_t exp_q [$];
   logic [63:0] hold_val = '0;

   always #5 clk = ~clk;

   des_iter_core u_dut (
      .clk(clk), .en_n(en_n), .blk_in(blk_in), .key_in(key_in),
      .dec_sel(dec_sel), .blk_out(blk_out), .done(done)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // Driver: called at a falling edge while idle or during a done cycle.
   task automatic run_block(input string tag, input logic [63:0] pt, input logic [63:0] k,
                            input logic dec, input logic [63:0] exp,
                            input int abort_at, input bit poke);
      blk_in = pt; key_in = k; dec_sel = dec; en_n = 1'b0;
      if (abort_at == 0) exp_q.push_back('{val: exp, tag: tag});
      for (int c = 1; c <= 17; c++) begin
         @(negedge clk);
         if (poke && c == 3) begin
            blk_in = ~pt; key_in = ~k; dec_sel = ~dec;  // R5
         end
         if (c == 8) chk("R9 output held mid-block", blk_out, hold_val);
         if (c == abort_at) begin
            en_n = 1'b1;                                 // R6 abort
            for (int w = 0; w < 3; w++) begin
               @(negedge clk);
               chk("R6 no done after abort", {63'd0, done}, 64'd0);
               chk("R7 output cleared", blk_out, 64'd0);
            end
            hold_val = '0;
            return;
         end
         if (c < 17) chk("R4 done low during rounds", {63'd0, done}, 64'd0);
         else        chk("R4 done on 17th edge", {63'd0, done}, 64'd1);
      end
      hold_val = exp;
   endtask

   // Monitor: scoreboard compare on each result pulse.
   initial begin
      forever begin
         @(negedge clk);
         if (done) begin
            if (exp_q.size() == 0) begin
               n_chk++; n_fail++;
               $display("FAIL R4 unexpected done actual=%h expected=none", blk_out);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk(e.tag, blk_out, e.val);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R4 watchdog expired actual=hung expected=finish");
      summary();
   end

   localparam logic [63:0] K1 = 64'h133457799BBCDFF1, P1 = 64'h0123456789ABCDEF, C1 = 64'h85E813540F0AB405;
   localparam logic [63:0] K2 = 64'h0000000000000000, P2 = 64'h0000000000000000, C2 = 64'h8CA64DE9C1B123A7;
   localparam logic [63:0] K3 = 64'h0E329232EA6D0D73, P3 = 64'h8787878787878787, C3 = 64'h0000000000000000;
   localparam logic [63:0] PAR = 64'h0101010101010101;

   initial begin
      repeat (4) @(negedge clk);
      chk("R7 idle done low", {63'd0, done}, 64'd0);
      chk("R7 idle output zero", blk_out, 64'd0);

      run_block("R1 encrypt vector 1", P1, K1, 1'b0, C1, 0, 0);
      run_block("R8 back-to-back encrypt vector 2", P2, K2, 1'b0, C2, 0, 0);
      run_block("R1 encrypt vector 3", P3, K3, 1'b0, C3, 0, 0);
      run_block("R2 decrypt vector 1", C1, K1, 1'b1, P1, 0, 0);
      run_block("R2 decrypt vector 2", C2, K2, 1'b1, P2, 0, 0);
      run_block("R2 decrypt vector 3", C3, K3, 1'b1, P3, 0, 0);
      run_block("R3 parity bits flipped, zero key", P2, K2 ^ PAR, 1'b0, C2, 0, 0);
      run_block("R3 parity bits flipped, encrypt", P1, K1 ^ PAR, 1'b0, C1, 0, 0);
      run_block("R3 parity bits flipped, decrypt", C1, K1 ^ PAR, 1'b1, P1, 0, 0);
      run_block("R5 inputs changed mid-block", P1, K1, 1'b0, C1, 0, 1);
      run_block("R6 aborted early", P3, K3, 1'b0, C3, 5, 0);
      run_block("R6 block after early abort", P3, K3, 1'b0, C3, 0, 0);
      run_block("R6 aborted before last round", P1, K1, 1'b0, C1, 16, 0);
      run_block("R6 block after late abort", C1, K1, 1'b1, P1, 0, 0);

      en_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R7 disabled output zero", blk_out, 64'd0);
      chk("R4 every expected result seen", 64'(exp_q.size()), 64'd0);
      summary();
   end
endmodule